// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives three pulse-width-modulated outputs from one shared 10-bit up counter. A prescaler picks the count rate from a set of divided system-clock taps or from a synchronised external clock. One period value fixes the frame length for all channels. Each channel has its own duty value, and the channel output is active from the start of the frame until the counter reaches that duty.

Software programs the block through a byte-wide write port. The low 8 bits of the period and of each duty value have their own addresses. The top 2 bits of all four values share one packed byte. Writes land in shadow storage. The active values copy over only when the counter wraps or while the counter is stopped, so no frame ever mixes old and new settings.

Each output has a polarity bit. When the counter is stopped, each output rests at a fixed level chosen by its polarity bit. A period match raises an interrupt flag, which is forwarded to the interrupt output only when the interrupt enable bit is set.

Top module: `pwm3_shared_period`

## Requirements
- R1: The clock-select field (address 6, bits [3:0]) picks the count rate. Codes 0 to 7 advance the counter once every 1, 2, 4, 8, 16, 64, 256 and 1024 system clocks respectively. Code 8 advances it once per rising edge of `ext_clk_i`. Codes 9 to 15 hold the counter still.
- R2: While running, `cnt_o` counts up by one per count tick. On the tick where it equals the active period it returns to 0. A frame is therefore period+1 ticks long. Stopping the block clears the counter to 0, and the counter has no write path.
- R3: The period's low byte is at address 0, and the duty low bytes of channels 0, 1 and 2 are at addresses 1, 2 and 3. Address 4 holds the high bits: [1:0] for the period, [3:2] for channel 0, [5:4] for channel 1 and [7:6] for channel 2.
- R4: Written period and duty values take effect only at a counter wrap or while the block is stopped. A duty write made mid-frame leaves the rest of that frame unchanged.
- R5: With polarity 0 and a duty D where 0 < D < period, an output is high while `cnt_o` < D and low for the rest of the frame.
- R6: A duty of 0 keeps the output at its inactive level. A duty greater than or equal to the period keeps it at its active level for the whole frame.
- R7: The control byte is at address 5: [0] run, [1] interrupt enable, [4:2] polarity for channels 0..2. Polarity 1 inverts a running output.
- R8: While stopped, an output is high if its polarity bit is 0 and low if it is 1.
- R9: A period match sets the interrupt flag. `irq_o` equals the flag ANDed with the enable bit, so a set flag appears at once when the enable bit is turned on.
- R10: Writing 1 to bit 0 of address 7 clears the flag. If a clear and a match fall in the same cycle, the flag stays set.
- R11: After reset the counter is 0, the block is stopped, all polarities are 0 (so `pwm_o` is 3'b111), and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| cnt_o | output | 10 | Current counter value |
| pwm_o | output | 3 | PWM outputs, bit c is channel c |
| irq_o | output | 1 | Period-match interrupt request |

## Verification
The interrupt flag's set-by-match and its clear-by-write can fall on the same clock edge. The bench provokes this by watching `cnt_o`. When it reads the active period while running undivided, the bench drives the clear write, so the next edge carries both the wrap and the clear. The bench then requires `irq_o` to remain high, and afterwards requires a clear issued away from any match to drop it. A second collision, a duty write landing mid-frame, is judged by requiring the old duty to govern until `cnt_o` returns to 0 and the new duty to govern afterwards.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int CW   = 10;
  localparam int DW   = 8;
  localparam int NCH  = 3;
  localparam int NTAP = 8;

  // divider exponent for each clock-select code below NTAP
  function automatic int tap_shift(input int i);
    case (i)
      0, 1, 2, 3, 4: return i;
      5:             return 6;
      6:             return 8;
      default:       return 10;
    endcase
  endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm3_pkg::*;
#(
  parameter int N_TAP = NTAP,
  parameter int SEL_W = $clog2(NTAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_clk_i,
  output logic             tick_o
);
  localparam int DIV_W = tap_shift(N_TAP - 1);
  localparam int IDX_W = $clog2(N_TAP);

  logic [DIV_W-1:0] div_q;
  logic [N_TAP-1:0] tap;
  logic [2:0]       ext_sync_q;
  logic             ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + 1'b1;

  for (genvar i = 0; i < N_TAP; i++) begin : g_tap
    localparam int SH = tap_shift(i);
    if (SH == 0) begin : g_full
      assign tap[i] = 1'b1;
    end else begin : g_div
      assign tap[i] = &div_q[SH-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ext_sync_q <= '0;
    else         ext_sync_q <= {ext_sync_q[1:0], ext_clk_i};

  assign ext_rise = ext_sync_q[1] & ~ext_sync_q[2];

  always_comb begin
    tick_o = 1'b0;
    if (run_i) begin
      if (sel_i < SEL_W'(N_TAP))       tick_o = tap[sel_i[IDX_W-1:0]];
      else if (sel_i == SEL_W'(N_TAP)) tick_o = ext_rise;
    end
  end
endmodule

// File: rtl/pwm_base_cnt.sv
module pwm_base_cnt
  import pwm3_pkg::*;
#(
  parameter int C_W = CW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic [C_W-1:0] per_sh_i,
  output logic [C_W-1:0] cnt_o,
  output logic [C_W-1:0] per_act_o,
  output logic           wrap_o,
  output logic           load_o
);
  logic [C_W-1:0] cnt_q, per_q;

  assign wrap_o    = run_i && tick_i && (cnt_q == per_q);
  assign load_o    = !run_i || wrap_o;
  assign cnt_o     = cnt_q;
  assign per_act_o = per_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      if (load_o)      per_q <= per_sh_i;
      if (load_o)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_q);
  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_q == per_q) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm3_pkg::*;
#(
  parameter int C_W = CW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic           wrap_i,
  input  logic [C_W-1:0] cnt_i,
  input  logic [C_W-1:0] per_act_i,
  input  logic [C_W-1:0] duty_sh_i,
  input  logic           pol_i,
  output logic           pwm_o
);
  logic [C_W-1:0] duty_q;
  logic           sr_q;
  logic           set_c, rst_c;

  // set at frame start (or while idle) unless the incoming duty is zero
  assign set_c = (!run_i || wrap_i) && (duty_sh_i != '0);
  assign rst_c = ((!run_i || wrap_i) && (duty_sh_i == '0)) ||
                 (run_i && tick_i && !wrap_i && (duty_q < per_act_i) &&
                  ({1'b0, cnt_i} + (C_W+1)'(1) == {1'b0, duty_q}));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      duty_q <= '0;
      sr_q   <= 1'b0;
    end else begin
      if (!run_i || wrap_i) duty_q <= duty_sh_i;
      if (set_c)            sr_q <= 1'b1;
      else if (rst_c)       sr_q <= 1'b0;
    end

  assign pwm_o = run_i ? (sr_q ^ pol_i) : ~pol_i;

  // R6
  duty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == '0) |-> !sr_q);
  // R6
  duty_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q != '0 && duty_q >= per_act_i) |-> sr_q);
endmodule

// File: rtl/pwm3_shared_period.sv
module pwm3_shared_period
  import pwm3_pkg::*;
#(
  parameter int C_W   = CW,
  parameter int D_W   = DW,
  parameter int N_CH  = NCH,
  parameter int N_TAP = NTAP,
  localparam int HW    = C_W - D_W,
  localparam int AW    = $clog2(N_CH + 5),
  localparam int SEL_W = $clog2(N_TAP + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [D_W-1:0]  wr_data_i,
  input  logic            ext_clk_i,
  output logic [C_W-1:0]  cnt_o,
  output logic [N_CH-1:0] pwm_o,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_PER  = '0;
  localparam logic [AW-1:0] A_HI   = AW'(N_CH + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(N_CH + 2);
  localparam logic [AW-1:0] A_SEL  = AW'(N_CH + 3);
  localparam logic [AW-1:0] A_CLR  = AW'(N_CH + 4);

  logic [D_W-1:0]             per_lo_q, hi_q;
  logic [N_CH-1:0][D_W-1:0]   duty_lo_q;
  logic                       run_q, irq_en_q, irq_q;
  logic [N_CH-1:0]            pol_q;
  logic [SEL_W-1:0]           sel_q;
  logic [C_W-1:0]             per_sh, per_act;
  logic [N_CH-1:0][C_W-1:0]   duty_sh;
  logic                       tick, wrap, load, clr_req;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      per_lo_q <= '0;
      hi_q     <= '0;
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
      pol_q    <= '0;
      sel_q    <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_PER:  per_lo_q <= wr_data_i;
        A_HI:   hi_q     <= wr_data_i;
        A_CTRL: begin
          run_q    <= wr_data_i[0];
          irq_en_q <= wr_data_i[1];
          pol_q    <= wr_data_i[2 +: N_CH];
        end
        A_SEL:  sel_q <= wr_data_i[SEL_W-1:0];
        default: ;
      endcase
    end

  for (genvar c = 0; c < N_CH; c++) begin : g_duty_reg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                  duty_lo_q[c] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(c + 1))  duty_lo_q[c] <= wr_data_i;
    assign duty_sh[c] = {hi_q[(c+1)*HW +: HW], duty_lo_q[c]};
  end

  assign per_sh  = {hi_q[0 +: HW], per_lo_q};
  assign clr_req = wr_en_i && (wr_addr_i == A_CLR) && wr_data_i[0];

  pwm_tick_gen #(.N_TAP(N_TAP), .SEL_W(SEL_W)) u_tick (
    .clk_i, .rst_ni, .run_i(run_q), .sel_i(sel_q), .ext_clk_i, .tick_o(tick)
  );

  pwm_base_cnt #(.C_W(C_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run_q), .tick_i(tick), .per_sh_i(per_sh),
    .cnt_o, .per_act_o(per_act), .wrap_o(wrap), .load_o(load)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_chan #(.C_W(C_W)) u_ch (
      .clk_i, .rst_ni, .run_i(run_q), .tick_i(tick), .wrap_i(wrap),
      .cnt_i(cnt_o), .per_act_i(per_act), .duty_sh_i(duty_sh[c]),
      .pol_i(pol_q[c]), .pwm_o(pwm_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      irq_q <= 1'b0;
    else if (wrap)    irq_q <= 1'b1;
    else if (clr_req) irq_q <= 1'b0;

  assign irq_o = irq_q & irq_en_q;

  // R9
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> irq_q);
  // R10
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !wrap) |=> !irq_q);
  // R4
  per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load) |-> $stable(per_act));
endmodule

// File: tb/sim_pwm3_shared_period.sv
module sim_pwm3_shared_period;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, ext_clk_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [9:0] cnt_o;
  logic [2:0] pwm_o;
  logic       irq_o;

  int checks = 0, errors = 0;

  pwm3_shared_period u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct packed {
    logic [9:0] per;
    logic [9:0] d0, d1, d2;
    logic [2:0] pol;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{per: 10'd9,   d0: 10'd3,   d1: 10'd0,    d2: 10'd12, pol: 3'b000},
    '{per: 10'd9,   d0: 10'd9,   d1: 10'd5,    d2: 10'd1,  pol: 3'b010},
    '{per: 10'd20,  d0: 10'd10,  d1: 10'd21,   d2: 10'd0,  pol: 3'b111},
    '{per: 10'd0,   d0: 10'd0,   d1: 10'd1,    d2: 10'd0,  pol: 3'b000},
    '{per: 10'd700, d0: 10'd350, d1: 10'd1023, d2: 10'd2,  pol: 3'b101}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic lvl(input int d, input int p, input int c, input logic pol);
    return (((d != 0) && (c < d || d >= p)) ? 1'b1 : 1'b0) ^ pol;
  endfunction

  // stop, program all values, then run with given polarity/irq enable
  task automatic setup(input vec_t v, input logic [3:0] sel, input logic ie);
    wr(3'd5, 8'h00);
    wr(3'd6, {4'h0, sel});
    wr(3'd0, v.per[7:0]);
    wr(3'd1, v.d0[7:0]);
    wr(3'd2, v.d1[7:0]);
    wr(3'd3, v.d2[7:0]);
    wr(3'd4, {v.d2[9:8], v.d1[9:8], v.d0[9:8], v.per[9:8]});
    wr(3'd5, {3'b000, v.pol, ie, 1'b1});
  endtask

  task automatic measure(input logic [3:0] sel, input int exp);
    vec_t v;
    int n;
    logic [9:0] last;
    v = '{per: 10'd1023, d0: 10'd1, d1: 10'd1, d2: 10'd1, pol: 3'b000};
    setup(v, sel, 1'b0);
    last = cnt_o;
    while (cnt_o == last) @(negedge clk_i);
    last = cnt_o; n = 0;
    while (cnt_o == last) begin @(negedge clk_i); n++; end
    // R1 divided tap rate
    check(n == exp, "R1", n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check(cnt_o == 0, "R11", cnt_o, 0);
    check(pwm_o == 3'b111, "R11", pwm_o, 7);
    check(irq_o == 1'b0, "R11", irq_o, 0);

    // R2 R3 R5 R6 R7: vector walk
    foreach (VEC[k]) begin
      int ce, pe[3], d[3];
      logic [9:0] prev;
      vec_t v;
      v = VEC[k];
      d[0] = v.d0; d[1] = v.d1; d[2] = v.d2;
      setup(v, 4'd0, 1'b0);
      ce = 0; pe = '{0, 0, 0};
      prev = cnt_o;
      if (cnt_o != 0) ce++;
      for (int i = 0; i < 2 * (v.per + 1) + 2; i++) begin
        for (int c = 0; c < 3; c++)
          if (pwm_o[c] !== lvl(d[c], v.per, cnt_o, v.pol[c])) pe[c]++;
        @(negedge clk_i);
        if (cnt_o != ((prev == v.per) ? 10'd0 : prev + 10'd1)) ce++;
        prev = cnt_o;
      end
      check(ce == 0, "R2", ce, 0);
      for (int c = 0; c < 3; c++)
        check(pe[c] == 0, (d[c] == 0 || d[c] >= v.per) ? "R6" :
                          (v.pol[c] ? "R7" : "R5"), pe[c], 0);
    end

    // R8 stop levels
    wr(3'd5, 8'b000_101_0_0);
    check(pwm_o == 3'b010, "R8", pwm_o, 2);
    wr(3'd5, 8'b000_010_0_0);
    check(pwm_o == 3'b101, "R8", pwm_o, 5);
    check(cnt_o == 0, "R2", cnt_o, 0);

    // R4 mid-frame duty write held until wrap
    begin
      vec_t v;
      int e1, e2;
      v = '{per: 10'd9, d0: 10'd3, d1: 10'd0, d2: 10'd0, pol: 3'b000};
      setup(v, 4'd0, 1'b0);
      while (cnt_o != 2) @(negedge clk_i);
      wr(3'd1, 8'd7);
      e1 = 0; e2 = 0;
      while (cnt_o != 0) begin
        if (pwm_o[0] !== lvl(3, 9, cnt_o, 1'b0)) e1++;
        @(negedge clk_i);
      end
      for (int i = 0; i < 10; i++) begin
        if (pwm_o[0] !== lvl(7, 9, cnt_o, 1'b0)) e2++;
        @(negedge clk_i);
      end
      check(e1 == 0, "R4", e1, 0);
      check(e2 == 0, "R4", e2, 0);
    end

    // R9 R10 interrupt
    begin
      vec_t v;
      v = '{per: 10'd9, d0: 10'd3, d1: 10'd0, d2: 10'd0, pol: 3'b000};
      setup(v, 4'd0, 1'b0);
      wr(3'd7, 8'h01);
      while (cnt_o != 9) @(negedge clk_i);
      @(negedge clk_i);
      check(irq_o == 1'b0, "R9", irq_o, 0);
      wr(3'd5, 8'b000_000_1_1);
      check(irq_o == 1'b1, "R9", irq_o, 1);
      while (cnt_o != 9) @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = 3'd7; wr_data_i = 8'h01;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      check(irq_o == 1'b1, "R10", irq_o, 1);
      while (cnt_o != 4) @(negedge clk_i);
      wr(3'd7, 8'h01);
      check(irq_o == 1'b0, "R10", irq_o, 0);
    end

    // R1 clock taps
    measure(4'd2, 4);
    measure(4'd4, 16);
    measure(4'd7, 1024);
    begin
      vec_t v;
      v = '{per: 10'd1023, d0: 10'd1, d1: 10'd1, d2: 10'd1, pol: 3'b000};
      setup(v, 4'd9, 1'b0);
      repeat (20) @(negedge clk_i);
      check(cnt_o == 0, "R1", cnt_o, 0);
      setup(v, 4'd8, 1'b0);
      repeat (10) begin
        repeat (3) @(negedge clk_i);
        ext_clk_i = 1'b1;
        repeat (3) @(negedge clk_i);
        ext_clk_i = 1'b0;
      end
      repeat (5) @(negedge clk_i);
      check(cnt_o == 10, "R1", cnt_o, 10);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule